// File: doc/BRIEF.md
# Shared-Memory Mailbox with Ownership Handoff

This block is a small mailbox aperture of eight 32-bit words that sits between two agents. The requester fills the mailbox and rings it. The responder services the request and posts a reply. Each agent has its own word-addressed write port and its own registered read port. Both ports reach the same storage.

A single ownership flag decides who may write from the requester side. It can be seen as bit 31 of word 7 and on the `owner_resp` output. When the requester writes word 7, that write is the doorbell: the flag moves to the responder and `req_ready` pulses for one cycle. The responder answers by writing a header into word 7 with bit 31 clear. This hands the mailbox back and pulses `rsp_ready`.

Requester writes made while the responder owns the mailbox are dropped, and a sticky error flag is raised. While `fn_reset` is high, every requester read returns all ones. The stored contents stay as they are. The block does not interpret the payload or the header fields. For reference, the header in word 7 uses msg_type in bits 2:0, version in 5:3 and direction in bit 7 (0 request, 1 response), status in bits 15:8, the reset request in bit 24 and ownership in bit 31.

Top module: `shm_mailbox`

## Requirements
- R1: After `rst` (synchronous, active high), the ownership flag is 0 (requester owns), all eight words read as zero on both ports, and `req_ready`, `rsp_ready` and `wr_err` are 0.
- R2: While the flag is 0, a requester write stores `rq_wdata` at word `rq_addr`. Both read ports present the word at their address one cycle after the address is applied. A read in the same cycle as a write to that word returns the old value.
- R3: An accepted requester write to word 7 sets the flag to 1 (bit 31 of word 7 reads 1 and `owner_resp` is 1 after that edge) and makes `req_ready` high for exactly the following cycle. Bits 30:0 of word 7 keep the written data.
- R4: A write to words 0 to 6 from either side never changes the ownership flag.
- R5: While the flag is 1, requester writes to any word are ignored and leave storage unchanged. `wr_err` goes to 1 on the next edge and stays 1 until `rst`.
- R6: A responder write to word 7 stores the word and loads the flag from `rs_wdata[31]`. If this clears a flag that was 1, `rsp_ready` is high for exactly the following cycle. A responder write is accepted whatever the flag value.
- R7: While `fn_reset` is high, `rq_rdata` is 0xFFFFFFFF from the next cycle on. The responder view, the storage and the flag are unaffected.
- R8: When both sides write the same word in one cycle, the responder's data is kept. For word 7 the flag follows the responder's bit 31, and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fn_reset | input | 1 | Function reset: forces the requester read view to all ones |
| rq_wr_en | input | 1 | Requester write strobe |
| rq_addr | input | 3 | Requester word index, used for both read and write |
| rq_wdata | input | 32 | Requester write data |
| rq_rdata | output | 32 | Requester read data, registered |
| rs_wr_en | input | 1 | Responder write strobe |
| rs_addr | input | 3 | Responder word index, used for both read and write |
| rs_wdata | input | 32 | Responder write data |
| rs_rdata | output | 32 | Responder read data, registered |
| owner_resp | output | 1 | Ownership flag: 1 means the responder owns the mailbox |
| req_ready | output | 1 | One-cycle pulse after the requester doorbell write |
| rsp_ready | output | 1 | One-cycle pulse after the responder returns ownership |
| wr_err | output | 1 | Sticky flag: a requester write was dropped |

## Verification
A wrong ownership flag shows up on `owner_resp` and in bit 31 of a word-7 read one cycle after the faulty write. It also shows up later, because requester writes are then wrongly dropped or accepted, and a read of that word reveals this a cycle after the address is applied. A misrouted or lost write stays in storage and is exposed only when either port next reads that word. For this reason the random phase reads a random word on both ports every cycle. Pulse and sticky-error mistakes appear at the very next edge after the triggering write.

// File: rtl/shm_mbx_pkg.sv
package shm_mbx_pkg;
  localparam int unsigned MBX_WORD_W = 32;
  localparam int unsigned MBX_WORDS  = 8;

  // Put the ownership flag into the top bit of the last word
  function automatic logic [MBX_WORD_W-1:0] mbx_view(
    input logic [MBX_WORD_W-1:0] raw,
    input logic                  is_last,
    input logic                  owner
  );
    logic [MBX_WORD_W-1:0] v;
    v = raw;
    if (is_last) v[MBX_WORD_W-1] = owner;
    return v;
  endfunction
endpackage

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int unsigned W  = 32,
  parameter int unsigned N  = 8,
  parameter int unsigned AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [W-1:0]  a_wdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [W-1:0]  b_wdata,
  input  logic [AW-1:0] a_raddr,
  input  logic [AW-1:0] b_raddr,
  output logic [W-1:0]  a_rword,
  output logic [W-1:0]  b_rword
);
  logic [W-1:0] mem [N];

  // Port b (responder) wins a same-word collision
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (rst) mem[i] <= '0;
      else if (b_we && b_addr == AW'(i)) mem[i] <= b_wdata;
      else if (a_we && a_addr == AW'(i)) mem[i] <= a_wdata;
    end
  end

  assign a_rword = mem[a_raddr];
  assign b_rword = mem[b_raddr];
endmodule

// File: rtl/mbx_owner.sv
module mbx_owner #(
  parameter int unsigned AW   = 3,
  parameter int unsigned LAST = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rq_we,
  input  logic [AW-1:0] rq_addr,
  input  logic          rs_we,
  input  logic [AW-1:0] rs_addr,
  input  logic          rs_flag,
  output logic          rq_accept,
  output logic          owner_q,
  output logic          req_pulse,
  output logic          rsp_pulse,
  output logic          err_q
);
  logic rs_last, rq_last;

  assign rq_accept = rq_we & ~owner_q;
  assign rs_last   = rs_we && rs_addr == AW'(LAST);
  assign rq_last   = rq_accept && rq_addr == AW'(LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q   <= 1'b0;
      req_pulse <= 1'b0;
      rsp_pulse <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      req_pulse <= rq_last & ~rs_last;
      rsp_pulse <= rs_last & owner_q & ~rs_flag;
      if (rq_we && owner_q) err_q <= 1'b1;
      if (rs_last)      owner_q <= rs_flag;
      else if (rq_last) owner_q <= 1'b1;
    end
  end

  // R3
  handoff_owner_chk: assert property (@(posedge clk) disable iff (rst)
    req_pulse |-> owner_q);
  // R6
  return_owner_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_pulse |-> !owner_q);
  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_pulse && rsp_pulse));
  // R5
  sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
  // R4
  low_word_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (!(rs_we && rs_addr == AW'(LAST)) && !(rq_we && rq_addr == AW'(LAST)))
      |=> $stable(owner_q));
endmodule

// File: rtl/mbx_readport.sv
module mbx_readport #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ones,
  input  logic         is_last,
  input  logic         owner,
  input  logic [W-1:0] raw,
  output logic [W-1:0] rdata
);
  import shm_mbx_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)       rdata <= '0;
    else if (ones) rdata <= '1;
    else           rdata <= W'(mbx_view(MBX_WORD_W'(raw), is_last, owner));
  end

  // R7
  reset_view_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ones) && !$past(rst)) |-> (rdata == '1));
endmodule

// File: rtl/shm_mailbox.sv
module shm_mailbox
  import shm_mbx_pkg::*;
#(
  parameter int unsigned WORD_W = MBX_WORD_W,
  parameter int unsigned NWORDS = MBX_WORDS,
  localparam int unsigned AW    = $clog2(NWORDS),
  localparam int unsigned LAST  = NWORDS - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fn_reset,
  input  logic              rq_wr_en,
  input  logic [AW-1:0]     rq_addr,
  input  logic [WORD_W-1:0] rq_wdata,
  output logic [WORD_W-1:0] rq_rdata,
  input  logic              rs_wr_en,
  input  logic [AW-1:0]     rs_addr,
  input  logic [WORD_W-1:0] rs_wdata,
  output logic [WORD_W-1:0] rs_rdata,
  output logic              owner_resp,
  output logic              req_ready,
  output logic              rsp_ready,
  output logic              wr_err
);
  logic              rq_accept;
  logic [WORD_W-1:0] rq_raw, rs_raw;

  mbx_owner #(.AW(AW), .LAST(LAST)) u_owner (
    .clk(clk), .rst(rst),
    .rq_we(rq_wr_en), .rq_addr(rq_addr),
    .rs_we(rs_wr_en), .rs_addr(rs_addr), .rs_flag(rs_wdata[WORD_W-1]),
    .rq_accept(rq_accept), .owner_q(owner_resp),
    .req_pulse(req_ready), .rsp_pulse(rsp_ready), .err_q(wr_err)
  );

  mbx_store #(.W(WORD_W), .N(NWORDS), .AW(AW)) u_store (
    .clk(clk), .rst(rst),
    .a_we(rq_accept), .a_addr(rq_addr), .a_wdata(rq_wdata),
    .b_we(rs_wr_en),  .b_addr(rs_addr), .b_wdata(rs_wdata),
    .a_raddr(rq_addr), .b_raddr(rs_addr),
    .a_rword(rq_raw), .b_rword(rs_raw)
  );

  mbx_readport #(.W(WORD_W)) u_rq_rd (
    .clk(clk), .rst(rst), .ones(fn_reset),
    .is_last(rq_addr == AW'(LAST)), .owner(owner_resp),
    .raw(rq_raw), .rdata(rq_rdata)
  );

  mbx_readport #(.W(WORD_W)) u_rs_rd (
    .clk(clk), .rst(rst), .ones(1'b0),
    .is_last(rs_addr == AW'(LAST)), .owner(owner_resp),
    .raw(rs_raw), .rdata(rs_rdata)
  );

  // R5
  drop_write_chk: assert property (@(posedge clk) disable iff (rst)
    (rq_wr_en && owner_resp) |=> wr_err);
endmodule

// File: tb/test_shm_mailbox.sv
module test_shm_mailbox;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fn_reset = 1'b0;
  logic        rq_wr_en = 1'b0, rs_wr_en = 1'b0;
  logic [2:0]  rq_addr = '0, rs_addr = '0;
  logic [31:0] rq_wdata = '0, rs_wdata = '0;
  logic [31:0] rq_rdata, rs_rdata;
  logic        owner_resp, req_ready, rsp_ready, wr_err;

  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [31:0] m_mem [8];
  bit m_own, m_err;

  always #5 clk = ~clk;

  shm_mailbox i_shm_mailbox (
    .clk(clk), .rst(rst), .fn_reset(fn_reset),
    .rq_wr_en(rq_wr_en), .rq_addr(rq_addr), .rq_wdata(rq_wdata), .rq_rdata(rq_rdata),
    .rs_wr_en(rs_wr_en), .rs_addr(rs_addr), .rs_wdata(rs_wdata), .rs_rdata(rs_rdata),
    .owner_resp(owner_resp), .req_ready(req_ready), .rsp_ready(rsp_ready), .wr_err(wr_err)
  );

  function automatic logic [31:0] view(input logic [2:0] a);
    logic [31:0] v;
    v = m_mem[a];
    if (a == 3'd7) v[31] = m_own;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check registered results at the next negedge
  task automatic step(input string tag,
                      input bit rqw, input logic [2:0] rqa, input logic [31:0] rqd,
                      input bit rsw, input logic [2:0] rsa, input logic [31:0] rsd,
                      input bit fr);
    logic [31:0] e_rq, e_rs;
    bit acc, e_req, e_rsp;
    e_rq  = fr ? 32'hFFFF_FFFF : view(rqa);
    e_rs  = view(rsa);
    acc   = rqw && !m_own;
    e_req = acc && rqa == 3'd7 && !(rsw && rsa == 3'd7);
    e_rsp = rsw && rsa == 3'd7 && m_own && !rsd[31];
    if (rqw && m_own) m_err = 1'b1;
    if (acc && !(rsw && rsa == rqa)) m_mem[rqa] = rqd;
    if (rsw) m_mem[rsa] = rsd;
    if (rsw && rsa == 3'd7) m_own = rsd[31];
    else if (e_req) m_own = 1'b1;
    rq_wr_en = rqw; rq_addr = rqa; rq_wdata = rqd;
    rs_wr_en = rsw; rs_addr = rsa; rs_wdata = rsd;
    fn_reset = fr;
    @(negedge clk);
    rq_wr_en = 1'b0; rs_wr_en = 1'b0;
    chk({tag, " R2 R7 rq_rdata"}, rq_rdata, e_rq);
    chk({tag, " R2 rs_rdata"}, rs_rdata, e_rs);
    chk({tag, " R3 R4 R6 owner_resp"}, 32'(owner_resp), 32'(m_own));
    chk({tag, " R3 req_ready"}, 32'(req_ready), 32'(e_req));
    chk({tag, " R6 rsp_ready"}, 32'(rsp_ready), 32'(e_rsp));
    chk({tag, " R5 wr_err"}, 32'(wr_err), 32'(m_err));
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 8; i++) m_mem[i] = '0;
    m_own = 1'b0; m_err = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state, every word on both ports
    for (int i = 0; i < 8; i++) step("R1", 0, 3'(i), 0, 0, 3'(7 - i), 0, 0);
    // R2: fill words 0..6; R4: no ownership change
    for (int i = 0; i < 7; i++) step("R2 R4 fill", 1, 3'(i), 32'hA000_0000 + i, 0, 3'(i), 0, 0);
    step("R2 readback", 0, 3'd3, 0, 0, 3'd5, 0, 0);
    // R3: doorbell
    step("R3 doorbell", 1, 3'd7, 32'h0100_0001, 0, 3'd0, 0, 0);
    step("R3 view", 0, 3'd7, 0, 0, 3'd7, 0, 0);
    // R5: dropped writes
    step("R5 drop", 1, 3'd2, 32'hDEAD_BEEF, 0, 3'd2, 0, 0);
    step("R5 drop7", 1, 3'd7, 32'h1234_5678, 0, 3'd2, 0, 0);
    step("R5 check", 0, 3'd2, 0, 0, 3'd7, 0, 0);
    // R4: responder writes a low word while owning
    step("R4 rs low", 0, 3'd0, 0, 1, 3'd1, 32'hFFFF_FFFF, 0);
    // R6: response header type 1, direction bit 7 = 1, status 0, bit 31 clear
    step("R6 reply", 0, 3'd0, 0, 1, 3'd7, 32'h0000_0081, 0);
    step("R6 view", 0, 3'd7, 0, 0, 3'd7, 0, 0);
    step("R6 noreturn", 0, 3'd0, 0, 1, 3'd7, 32'h0000_0082, 0);
    // R7: function reset view
    step("R7 on", 0, 3'd1, 0, 0, 3'd1, 0, 1);
    step("R7 hold", 0, 3'd7, 0, 0, 3'd7, 0, 1);
    step("R7 off", 0, 3'd1, 0, 0, 3'd1, 0, 0);
    // R8: collisions
    step("R8 same low", 1, 3'd4, 32'h1111_1111, 1, 3'd4, 32'h2222_2222, 0);
    step("R8 same 7", 1, 3'd7, 32'h0000_0001, 1, 3'd7, 32'h0000_0081, 0);
    step("R8 check", 0, 3'd4, 0, 0, 3'd7, 0, 0);
    // Random mix
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step("rand", r[0] | r[1], 3'($urandom_range(0, 7)), $urandom,
           (r[3:2] == 2'b00), 3'($urandom_range(0, 7)), $urandom,
           (r[7:4] == 4'h0));
    end
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule